// File: doc/BRIEF.md
# Four-Channel Double-Buffered PWM Timer

This block is a free-running up-counter shared by several pulse-width outputs. The counter ticks once every (prescale + 1) clocks. It climbs from zero to a programmed period value and then returns to zero. Each output is high while it is enabled and the counter is below that output's threshold. Writing a larger threshold widens the pulse, so the duty cycle is threshold / (period + 1).

Software programs the timer through a single-cycle write port. The period, the prescale value and every threshold are written into holding registers first. They move into the working registers only at an update event. An update event happens when the counter wraps, or when software writes the force register. A write made in the middle of a period therefore never produces a truncated or doubled pulse. A one-cycle update flag marks the cycle that starts each new period.

Top module: `pwm_tmr`

## Requirements
- R1: With prescale 0 and run set, the counter steps by one every clock from 0 up to the working period value, then returns to 0 on the next tick. The working period resets to all ones.
- R2: With working prescale value P, the counter advances once every P+1 clocks while run is set. The prescale value is written at address 3.
- R3: Output k is high exactly when its enable is set and the counter value is strictly below channel k's working threshold.
- R4: A threshold write (address 4+k) changes only the holding copy. Output k keeps following the old threshold until the next update event.
- R5: Period writes (address 2) and prescale writes (address 3) take effect only from the next update event.
- R6: A write to address 1 with data bit 0 set clears the counter and the prescale phase, and loads all working registers from their holding copies at that edge. A write there with bit 0 clear has no effect.
- R7: A channel whose working threshold is 0 stays low for the whole period.
- R8: `upd_o` is high for exactly the one cycle that follows each update event, whether the event came from a wrap or from a forced update.
- R9: The counter and prescale phase hold their values while the run bit (address 0, bit 0) is clear.
- R10: Channel k is enabled by bit 4+k of address 0. A disabled channel drives 0 whatever its threshold.
- R11: An enabled channel whose working threshold is above the working period stays high for the entire period.
- R12: After reset, the counter, `upd_o` and all outputs are 0, run is clear and all thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one register per cycle |
| wr_addr_i | input | 3 | Register address: 0 control, 1 force, 2 period, 3 prescale, 4+k threshold k |
| wr_data_i | input | 16 | Write data |
| pwm_o | output | 4 | Pulse outputs, one per channel |
| cnt_o | output | 16 | Current counter value |
| upd_o | output | 1 | Update flag, high for one cycle after each update event |

## Verification
Every register sits one edge away from the write port. A write or force captured at a rising edge shows on `cnt_o` and `upd_o` in the cycle that follows that edge. A threshold or period write has no visible effect until the cycle after the next update event. The outputs are decoded from the counter and the working thresholds without another register, so `pwm_o` is valid in the same cycle as the `cnt_o` it belongs to. The bench samples every output at the falling edge. It compares against a cycle model that advances exactly once per rising edge, using the inputs driven during the previous half period, so each expectation lines up with the edge that produced it.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  // register address map
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_FRC  = 1;
  localparam int unsigned REG_PER  = 2;
  localparam int unsigned REG_PSC  = 3;
  localparam int unsigned REG_CMP0 = 4;

  // control word fields
  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_EN_LSB  = 4;

  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_WRAP = 2'd1,
    UPD_SW   = 2'd2
  } upd_src_e;

  // a forced update wins the label when both coincide
  function automatic upd_src_e upd_cause(input logic wrap, input logic sw);
    if (sw)        return UPD_SW;
    else if (wrap) return UPD_WRAP;
    else           return UPD_NONE;
  endfunction

endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter logic [CNT_W-1:0] RST_PER = '1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  output logic                       run_o,
  output logic [NCH-1:0]             ch_en_o,
  output logic [CNT_W-1:0]           per_sh_o,
  output logic [PSC_W-1:0]           psc_sh_o,
  output logic [NCH-1:0][CNT_W-1:0]  cmp_sh_o,
  output logic                       frc_o
);

  function automatic logic hit(input logic en, input logic [ADDR_W-1:0] a,
                               input int unsigned target);
    return en && (a == ADDR_W'(target));
  endfunction

  logic unused_data;
  assign unused_data = ^wr_data_i;

  assign frc_o = hit(wr_en_i, wr_addr_i, REG_FRC) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o    <= 1'b0;
      ch_en_o  <= '0;
      per_sh_o <= RST_PER;
      psc_sh_o <= '0;
    end else begin
      if (hit(wr_en_i, wr_addr_i, REG_CTRL)) begin
        run_o   <= wr_data_i[CTRL_RUN_BIT];
        ch_en_o <= wr_data_i[CTRL_EN_LSB +: NCH];
      end
      if (hit(wr_en_i, wr_addr_i, REG_PER)) per_sh_o <= wr_data_i;
      if (hit(wr_en_i, wr_addr_i, REG_PSC)) psc_sh_o <= wr_data_i[PSC_W-1:0];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_cmp_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cmp_sh_o[k] <= '0;
      else if (hit(wr_en_i, wr_addr_i, REG_CMP0 + k))
        cmp_sh_o[k] <= wr_data_i;
    end
  end

endmodule

// File: rtl/pwm_tmr_timebase.sv
module pwm_tmr_timebase
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  parameter logic [CNT_W-1:0] RST_PER = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             frc_i,
  input  logic [CNT_W-1:0] per_sh_i,
  input  logic [PSC_W-1:0] psc_sh_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_act_o,
  output logic             tick_o,
  output logic             wrap_o,
  output logic             upd_evt_o,
  output logic             upd_q_o
);

  logic [PSC_W-1:0] psc_ph;
  logic [PSC_W-1:0] psc_act;
  upd_src_e         src;

  function automatic logic [PSC_W-1:0] psc_step(input logic [PSC_W-1:0] cur,
                                                input logic [PSC_W-1:0] lim);
    return (cur == lim) ? '0 : cur + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] lim);
    return (cur == lim) ? '0 : cur + 1'b1;
  endfunction

  assign tick_o    = run_i && (psc_ph == psc_act);
  assign wrap_o    = tick_o && (cnt_o == per_act_o);
  assign src       = upd_cause(wrap_o, frc_i);
  assign upd_evt_o = (src != UPD_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      psc_ph    <= '0;
      per_act_o <= RST_PER;
      psc_act   <= '0;
      upd_q_o   <= 1'b0;
    end else begin
      upd_q_o <= upd_evt_o;
      if (upd_evt_o) begin
        per_act_o <= per_sh_i;
        psc_act   <= psc_sh_i;
      end
      if (src == UPD_SW) begin
        cnt_o  <= '0;
        psc_ph <= '0;
      end else if (run_i) begin
        psc_ph <= psc_step(psc_ph, psc_act);
        if (tick_o) cnt_o <= cnt_step(cnt_o, per_act_o);
      end
    end
  end

endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cmp_sh_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic             pwm_o
);

  function automatic logic level(input logic en, input logic [CNT_W-1:0] cnt,
                                 input logic [CNT_W-1:0] thr);
    return en && (cnt < thr);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cmp_act_o <= '0;
    else if (upd_i) cmp_act_o <= cmp_sh_i;
  end

  assign pwm_o = level(en_i, cnt_i, cmp_act_o);

endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 16,
  parameter logic [CNT_W-1:0] RST_PER = '1,
  localparam int unsigned ADDR_W = $clog2(REG_CMP0 + NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [NCH-1:0]    pwm_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_o
);

  logic                      run;
  logic [NCH-1:0]            ch_en;
  logic [CNT_W-1:0]          per_sh;
  logic [PSC_W-1:0]          psc_sh;
  logic [NCH-1:0][CNT_W-1:0] cmp_sh;
  logic [NCH-1:0][CNT_W-1:0] cmp_act;
  logic [CNT_W-1:0]          per_act;
  logic                      frc_evt;
  logic                      tick;
  logic                      wrap_evt;
  logic                      upd_evt;

  pwm_tmr_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .PSC_W(PSC_W), .ADDR_W(ADDR_W), .RST_PER(RST_PER)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .run_o     (run),
    .ch_en_o   (ch_en),
    .per_sh_o  (per_sh),
    .psc_sh_o  (psc_sh),
    .cmp_sh_o  (cmp_sh),
    .frc_o     (frc_evt)
  );

  pwm_tmr_timebase #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .RST_PER(RST_PER)
  ) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .frc_i     (frc_evt),
    .per_sh_i  (per_sh),
    .psc_sh_i  (psc_sh),
    .cnt_o     (cnt_o),
    .per_act_o (per_act),
    .tick_o    (tick),
    .wrap_o    (wrap_evt),
    .upd_evt_o (upd_evt),
    .upd_q_o   (upd_o)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    pwm_tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .upd_i     (upd_evt),
      .en_i      (ch_en[k]),
      .cmp_sh_i  (cmp_sh[k]),
      .cnt_i     (cnt_o),
      .cmp_act_o (cmp_act[k]),
      .pwm_o     (pwm_o[k])
    );
  end

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
  parameter int unsigned NCH   = 4,
  parameter int unsigned CNT_W = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      run,
  input logic                      tick,
  input logic                      wrap_evt,
  input logic                      frc_evt,
  input logic                      upd_evt,
  input logic                      upd_o,
  input logic [CNT_W-1:0]          cnt_o,
  input logic [CNT_W-1:0]          per_act,
  input logic [NCH-1:0]            ch_en,
  input logic [NCH-1:0][CNT_W-1:0] cmp_act,
  input logic [NCH-1:0]            pwm_o
);

  p_wrap_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_evt |=> (cnt_o == '0));

  p_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !wrap_evt && !frc_evt) |=> (cnt_o == $past(cnt_o) + 1'b1));

  p_psc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick && !frc_evt) |=> $stable(cnt_o));

  p_per_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_evt |=> $stable(per_act));

  p_frc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc_evt |=> (cnt_o == '0));

  p_upd_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_evt || frc_evt) |=> upd_o);

  p_upd_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wrap_evt || frc_evt) |=> !upd_o);

  p_stop_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !frc_evt) |=> $stable(cnt_o));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    p_cmp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_evt |=> $stable(cmp_act[k]));

    p_zero_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_act[k] == '0) |-> !pwm_o[k]);

    p_dis_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en[k] |-> !pwm_o[k]);

    p_over_high_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ch_en[k] && (cmp_act[k] > per_act)) |-> pwm_o[k]);
  end

endmodule

bind pwm_tmr pwm_tmr_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run      (run),
  .tick     (tick),
  .wrap_evt (wrap_evt),
  .frc_evt  (frc_evt),
  .upd_evt  (upd_evt),
  .upd_o    (upd_o),
  .cnt_o    (cnt_o),
  .per_act  (per_act),
  .ch_en    (ch_en),
  .cmp_act  (cmp_act),
  .pwm_o    (pwm_o)
);

// File: tb/pwm_tmr_tb_top.sv
module pwm_tmr_tb_top;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm;
  logic [15:0] cnt;
  logic        upd;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pwm_tmr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .cnt_o(cnt), .upd_o(upd)
  );

  // cycle model of the requirements
  logic [15:0] m_cnt, m_ph, m_per_a, m_per_s, m_psc_a, m_psc_s;
  logic [15:0] m_thr_a [NCH];
  logic [15:0] m_thr_s [NCH];
  logic        m_run, m_upd, m_frc_last;
  logic [3:0]  m_en;

  function automatic logic exp_level(int k);
    if (!m_en[k]) return 1'b0;
    return (m_thr_a[k] > m_cnt);
  endfunction

  task automatic model_reset();
    m_cnt = 0; m_ph = 0; m_per_a = 16'hFFFF; m_per_s = 16'hFFFF;
    m_psc_a = 0; m_psc_s = 0; m_run = 0; m_upd = 0; m_frc_last = 0; m_en = 0;
    for (int k = 0; k < NCH; k++) begin m_thr_a[k] = 0; m_thr_s[k] = 0; end
  endtask

  task automatic model_edge(input logic we, input logic [2:0] a, input logic [15:0] d);
    logic tk, wr, fr;
    tk = m_run && (m_ph == m_psc_a);
    wr = tk && (m_cnt == m_per_a);
    fr = we && (a == 3'd1) && d[0];
    if (fr) begin m_cnt = 0; m_ph = 0; end
    else if (m_run) begin
      m_ph = tk ? 16'd0 : m_ph + 16'd1;
      if (tk) m_cnt = wr ? 16'd0 : m_cnt + 16'd1;
    end
    if (fr || wr) begin
      m_per_a = m_per_s; m_psc_a = m_psc_s;
      for (int k = 0; k < NCH; k++) m_thr_a[k] = m_thr_s[k];
    end
    if (we) begin
      case (a)
        3'd0: begin m_run = d[0]; m_en = d[7:4]; end
        3'd2: m_per_s = d;
        3'd3: m_psc_s = d;
        3'd4, 3'd5, 3'd6, 3'd7: m_thr_s[a - 3'd4] = d;
        default: ;
      endcase
    end
    m_upd = fr || wr;
    m_frc_last = fr;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // compare all outputs; tag chosen from the model state unless given
  task automatic compare(input string tag);
    string t;
    if (tag != "") t = tag;
    else if (m_frc_last) t = "R6";
    else if (!m_run) t = "R9";
    else if (m_psc_a != 0) t = "R2";
    else if (m_per_s != m_per_a) t = "R5";
    else t = "R1";
    chk(t, cnt, m_cnt);
    chk((tag != "") ? tag : (m_frc_last ? "R6" : "R8"), upd, m_upd);
    for (int k = 0; k < NCH; k++) begin
      if (tag != "") t = tag;
      else if (!m_en[k]) t = "R10";
      else if (m_thr_a[k] == 0) t = "R7";
      else if (m_thr_a[k] > m_per_a) t = "R11";
      else if (m_thr_s[k] != m_thr_a[k]) t = "R4";
      else t = "R3";
      chk(t, pwm[k], exp_level(k));
    end
  endtask

  task automatic cyc(input string tag, input logic we, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    compare(tag);
    wr_en = we; wr_addr = a; wr_data = d;
    model_edge(we, a, d);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 1'b0, 3'd0, 16'd0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [2:0]  ra;
    logic [15:0] rd;
    model_reset();
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R12: reset state at the ports
    chk("R12", cnt, 16'd0);
    chk("R12", pwm, 4'd0);
    chk("R12", upd, 1'b0);
    rst_n = 1'b1;
    idle("R12", 2);

    // program shadows: period 9, prescale 0, thresholds 0/4/9/15
    cyc("", 1, 3'd2, 16'd9);
    cyc("", 1, 3'd3, 16'd0);
    cyc("", 1, 3'd4, 16'd0);
    cyc("", 1, 3'd5, 16'd4);
    cyc("", 1, 3'd6, 16'd9);
    cyc("", 1, 3'd7, 16'd15);
    cyc("", 1, 3'd0, 16'h00F1);
    idle("R5", 4);              // period still all ones, thresholds 0
    cyc("", 1, 3'd1, 16'd1);    // force
    idle("", 30);               // R1, R3, R7, R11, R8
    // R4: mid-period threshold write
    idle("", 3);
    cyc("", 1, 3'd5, 16'd7);
    idle("R4", 5);
    idle("", 20);
    // R5: period change waits for the wrap
    cyc("", 1, 3'd2, 16'd4);
    idle("", 25);
    // R2: prescale of 2
    cyc("", 1, 3'd3, 16'd2);
    idle("R2", 40);
    // R9: stop the counter
    cyc("", 1, 3'd0, 16'h00F0);
    idle("R9", 6);
    // R10: channel 1 disabled, run again
    cyc("", 1, 3'd0, 16'h00D1);
    idle("R10", 12);
    // R6: force with bit 0 clear does nothing, then a real force
    cyc("", 1, 3'd1, 16'hFFFE);
    idle("R6", 3);
    cyc("", 1, 3'd1, 16'd1);
    idle("R6", 2);
    // R8: upd pulse after wrap observed through the model
    idle("R8", 20);

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        ra = 3'($urandom_range(0, 7));
        case (ra)
          3'd0: rd = {8'd0, 4'($urandom), 3'd0, 1'($urandom_range(0, 3) != 0)};
          3'd1: rd = 16'($urandom_range(0, 1));
          3'd2: rd = 16'($urandom_range(0, 15));
          3'd3: rd = 16'($urandom_range(0, 3));
          default: rd = 16'($urandom_range(0, 18));
        endcase
        cyc("", 1'b1, ra, rd);
      end else begin
        cyc("", 1'b0, 3'd0, 16'd0);
      end
    end
    idle("", 2);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule